// File: doc/BRIEF.md
# Chained CRC32 Bloom Filter Probe

This block is the per-level filter check of a trie-based address lookup. At each trie level the caller supplies the hash left by the previous level and one new key bit. That bit is the most significant bit of the part of the search key that is still active. The block folds the bit into a running reflected CRC32 in one update step. It then reads a single-bit Bloom memory at an index taken from the low bits of the new hash.

A stored one reports a hit, and the caller goes on to read its prefix storage. A stored zero reports a skip, and the caller leaves that prefix read out. Filtering is switched per level: on a level that is not filtered the block always reports a hit. The updated hash is returned so the caller can feed it back at the next level. The caller starts a walk by passing the seed value 0xFFFFFFFF, which is also the value the hash output holds after reset.

The filter contents are loaded through a plain one-bit write port. The trie walk itself is done by the caller.

Top module: `bloom_probe`

## Requirements
- R1: After reset, outValid, hit and skip are 0, nextCrc is 0xFFFFFFFF, and every Bloom memory bit is 0, so a filtered probe issued before any write reports skip.
- R2: A probe accepted on a clock edge with inValid high gives its result one cycle later. outValid is high in exactly the cycles that follow an edge with inValid high.
- R3: The new hash is one bit-serial step of the reflected CRC32 with polynomial 0xEDB88320. The feedback is prevCrc[0] XOR keyBit. The register shifts right by one, and the polynomial is XORed in when the feedback is 1. For example, seed 0xFFFFFFFF with keyBit 0 gives 0x92477CDF, and with keyBit 1 gives 0x7FFFFFFF.
- R4: nextCrc keeps its value through every cycle in which no probe is accepted.
- R5: On a probe with levelFilterEn high, the memory index is bits [9:0] of the new hash, and hit equals the stored bit at that index.
- R6: On a probe with levelFilterEn low, hit is 1 and skip is 0 whatever the memory holds.
- R7: skip is 1 exactly when outValid is 1 and hit is 0. hit and skip are both 0 while outValid is 0.
- R8: A write with wrEn high stores wrBit at wrAddr on that clock edge. A probe accepted on the same edge at the same index sees the old bit, and a probe accepted on any later edge sees the new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Probe strobe for this cycle |
| prevCrc | input | 32 | Hash left by the previous trie level (seed at the first level) |
| keyBit | input | 1 | Leading bit of the active key part for this level |
| levelFilterEn | input | 1 | Filtering is enabled for this level |
| wrEn | input | 1 | Bloom memory write strobe |
| wrAddr | input | 10 | Bloom memory write index |
| wrBit | input | 1 | Bit to store |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| nextCrc | output | 32 | Updated hash for the next level |
| hit | output | 1 | Prefix storage access required |
| skip | output | 1 | Prefix storage access may be omitted |

## Verification
A wrong hash step shows in nextCrc on the very cycle after the probe. Because the index is taken from that hash, it also tends to flip hit and skip in that same cycle. A wrong or stale Bloom bit can only be seen when a filtered probe lands on that index, so the random stimulus writes over the whole memory and probes it heavily, with hashes chained from level to level. Directed probes cover the write and read collision on one edge, unfiltered levels over stored zeros, and the reset contents.

// File: rtl/bloom_probe_pkg.sv
package bloom_probe_pkg;

  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // a probe is accepted this edge
    logic filterOn;  // accepted probe uses the Bloom memory
    logic bypass;    // accepted probe on an unfiltered level
  } probeStrobe_t;

  // One bit-serial step of a reflected CRC
  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] cur,
                                               input logic inBit);
    logic fb;
    logic [CRC_W-1:0] sh;
    fb = cur[0] ^ inBit;
    sh = cur >> 1;
    return fb ? (sh ^ CRC_POLY) : sh;
  endfunction

endpackage

// File: rtl/bloom_probe_ctrl.sv
module bloom_probe_ctrl
  import bloom_probe_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         levelFilterEn,
  output probeStrobe_t strobe,
  output logic         outValid
);

  always_comb begin
    strobe.capture  = inValid;
    strobe.filterOn = inValid & levelFilterEn;
    strobe.bypass   = inValid & ~levelFilterEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: result strobe echoes the probe strobe one cycle later
  a_r2_valid_echo: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/bloom_probe_dp.sv
module bloom_probe_dp
  import bloom_probe_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  probeStrobe_t      strobe,
  input  logic [CRC_W-1:0]  prevCrc,
  input  logic              keyBit,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic              wrBit,
  output logic [CRC_W-1:0]  nextCrc,
  output logic              hit,
  output logic              skip
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [CRC_W-1:0] crcNew;
  logic [IDX_W-1:0] rdIdx;
  logic             rdBit;
  logic [DEPTH-1:0] bloomMem;
  logic [CRC_W-1:0] crcQ;
  logic             hitQ;
  logic             skipQ;

  always_comb begin
    crcNew = crcStep(prevCrc, keyBit);
    rdIdx  = crcNew[IDX_W-1:0];
    rdBit  = bloomMem[rdIdx];
  end

  // Bloom memory: one bit per index, cleared by reset
  always_ff @(posedge clk) begin
    if (!rstN)     bloomMem <= '0;
    else if (wrEn) bloomMem[wrAddr] <= wrBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ  <= CRC_SEED;
      hitQ  <= 1'b0;
      skipQ <= 1'b0;
    end else begin
      if (strobe.capture) crcQ <= crcNew;
      hitQ  <= strobe.bypass | (strobe.filterOn & rdBit);
      skipQ <= strobe.filterOn & ~rdBit;
    end
  end

  assign nextCrc = crcQ;
  assign hit     = hitQ;
  assign skip    = skipQ;

  // R4: hash output holds while no probe is accepted
  a_r4_crc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(crcQ));
  // R6: an unfiltered level always reports a hit
  a_r6_bypass_hit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bypass |=> (hit && !skip));
  // R8: a write is visible at its index on the next cycle
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> bloomMem[$past(wrAddr)] == $past(wrBit));
  // R3: the top hash bit after a step equals the feedback bit
  a_r3_feedback_msb: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> crcQ[CRC_W-1] == ($past(prevCrc[0]) ^ $past(keyBit)));

endmodule

// File: rtl/bloom_probe.sv
module bloom_probe
  import bloom_probe_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [31:0]      prevCrc,
  input  logic             keyBit,
  input  logic             levelFilterEn,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic             wrBit,
  output logic             outValid,
  output logic [31:0]      nextCrc,
  output logic             hit,
  output logic             skip
);

  probeStrobe_t strobe;

  bloom_probe_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .levelFilterEn (levelFilterEn),
    .strobe        (strobe),
    .outValid      (outValid)
  );

  bloom_probe_dp #(.IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .prevCrc (prevCrc),
    .keyBit  (keyBit),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrBit   (wrBit),
    .nextCrc (nextCrc),
    .hit     (hit),
    .skip    (skip)
  );

  // R7: skip only on a valid result that is not a hit
  a_r7_skip_valid: assert property (@(posedge clk) disable iff (!rstN)
    skip |-> (outValid && !hit));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!hit && !skip));
  a_r7_valid_decides: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (hit != skip));

endmodule

// File: tb/tb_bloom_probe.sv
module tb_bloom_probe;

  localparam int unsigned IDX_W = 10;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [31:0]      prevCrc = '0;
  logic             keyBit = 1'b0;
  logic             levelFilterEn = 1'b0;
  logic             wrEn = 1'b0;
  logic [IDX_W-1:0] wrAddr = '0;
  logic             wrBit = 1'b0;
  logic             outValid;
  logic [31:0]      nextCrc;
  logic             hit;
  logic             skip;

  int errors = 0;
  int checks = 0;

  logic             model [DEPTH];
  logic             expValid = 1'b0;
  logic [31:0]      expCrc = 32'hFFFFFFFF;
  logic             expHit = 1'b0;
  logic             expSkip = 1'b0;
  logic             prevAccepted = 1'b0;

  always #5 clk = ~clk;

  bloom_probe #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .prevCrc(prevCrc),
    .keyBit(keyBit), .levelFilterEn(levelFilterEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrBit(wrBit), .outValid(outValid),
    .nextCrc(nextCrc), .hit(hit), .skip(skip)
  );

  function automatic logic [31:0] refStep(input logic [31:0] c, input logic b);
    logic f;
    f = c[0] ^ b;
    c = {1'b0, c[31:1]};
    if (f) c = c ^ 32'hEDB88320;
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Check outputs of the previous probe, then drive a new cycle
  task automatic cycle(input logic v, input logic [31:0] pc, input logic kb,
                       input logic en, input logic we, input logic [IDX_W-1:0] wa,
                       input logic wb);
    logic [31:0] nc;
    @(negedge clk);
    check("R2 outValid", {31'b0, outValid}, {31'b0, expValid});
    check(prevAccepted ? "R3 nextCrc" : "R4 nextCrc hold", nextCrc, expCrc);
    check(expHit && !expSkip && expValid ? "R5/R6 hit" : "R5 R7 hit", {31'b0, hit}, {31'b0, expHit});
    check("R7 skip", {31'b0, skip}, {31'b0, expSkip});
    inValid = v; prevCrc = pc; keyBit = kb; levelFilterEn = en;
    wrEn = we; wrAddr = wa; wrBit = wb;
    prevAccepted = v;
    expValid = v;
    if (v) begin
      nc = refStep(pc, kb);
      expCrc = nc;
      expHit = en ? model[nc[IDX_W-1:0]] : 1'b1;   // read before this edge's write (R8)
      expSkip = en & ~model[nc[IDX_W-1:0]];
    end else begin
      expHit = 1'b0;
      expSkip = 1'b0;
    end
    if (we) model[wa] = wb;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] r;
    seed = 32'h1BAD5EED;
    r = $urandom(seed);
    for (int i = 0; i < DEPTH; i++) model[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    @(negedge clk);
    check("R1 outValid", {31'b0, outValid}, 32'd0);
    check("R1 nextCrc", nextCrc, 32'hFFFFFFFF);
    check("R1 hit", {31'b0, hit}, 32'd0);
    check("R1 skip", {31'b0, skip}, 32'd0);
    // R3 known steps from the seed; R1 empty memory gives skip
    cycle(1'b1, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    check("R3 literal seed/0", expCrc, 32'h92477CDF);
    cycle(1'b1, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    check("R3 literal seed/1", expCrc, 32'h7FFFFFFF);
    // R8 collision: probe index 0 while writing 1 there
    cycle(1'b1, 32'h0, 1'b0, 1'b1, 1'b1, '0, 1'b1);
    cycle(1'b1, 32'h0, 1'b0, 1'b1, 1'b0, '0, 1'b0);
    // R6 unfiltered level over a stored zero (index of 0x7FFFFFFF)
    cycle(1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    // R4 idle cycles hold the hash
    cycle(1'b0, 32'h12345678, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    cycle(1'b0, 32'hCAFEF00D, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    // Random phase with chained hashes and dense writes
    for (int n = 0; n < 6000; n++) begin
      logic v, kb, en, we, wb, chain;
      logic [31:0] pc;
      logic [IDX_W-1:0] wa;
      v = ($urandom % 4) != 0;
      kb = $urandom % 2;
      en = ($urandom % 4) != 0;
      we = ($urandom % 2) != 0;
      wb = $urandom % 2;
      wa = IDX_W'($urandom);
      chain = ($urandom % 8) != 0;
      pc = chain ? expCrc : $urandom;
      if (($urandom % 64) == 0) pc = 32'hFFFFFFFF;
      cycle(v, pc, kb, en, we, wa, wb);
    end
    cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule